// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block translates 32-bit effective data addresses into physical addresses using 4 KB pages held in a small set-associative table. Software fills the table. Each entry is a pair of 32-bit registers. The match register holds a virtual page number and a valid flag. The translate register holds a physical page number, a cache-inhibit attribute and four access-enable bits: read and write, each for user and supervisor mode. The block never refills an entry by itself.

On each load or store request, the page number selects a set. Every way of that set compares its stored page number against the address. The block checks the hitting entry's enables against the current privilege mode and access type. One cycle later it returns one of three results: the translated address, a miss, or a page fault. A miss means no valid way matched. A page fault means an entry matched but forbids the access. For either exception the block latches the offending effective address. When translation is switched off, addresses pass through unchanged and no exceptions are raised.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset, all table registers read as zero. `rsp_valid`, `rsp_miss`, `rsp_fault`, `rsp_nocache`, `rsp_pa` and `fault_addr` are all zero.
- R2: With `xlate_en` low, a request returns `rsp_pa` equal to the request address one cycle later, with `rsp_miss`, `rsp_fault` and `rsp_nocache` low, whatever the table holds.
- R3: The set index is effective-address bits [12 +: log2(NUM_SETS)]. On a permitted hit, `rsp_pa` is the translate register's bits 31:12 followed by address bits 11:0.
- R4: An entry whose match-register bit 0 (valid) is clear never hits, even when its bits 31:12 equal the page number.
- R5: A hit needs every one of address bits 31:12 to equal match-register bits 31:12. A single differing bit gives a miss, and any offset from 0x000 to 0xFFF in a matching page hits.
- R6: When a request ends in a miss or a page fault, `fault_addr` takes that request's effective address in the same cycle as the exception flag. At all other times `fault_addr` holds its value.
- R7: The translate register's permission bits are: bit 1 user read, bit 2 user write, bit 3 supervisor read, bit 4 supervisor write. A hit whose enable for the current mode (`priv_super`) and access type (`req_write`) is clear raises `rsp_fault` instead of translating.
- R8: When several valid ways of a set match, the lowest-numbered way supplies the translation and permissions.
- R9: Each register is addressed by `cfg_sel_tr` (0 = match, 1 = translate), `cfg_way` and `cfg_set`. A write with `cfg_wr` stores `cfg_wdata` at the clock edge. `cfg_rdata` shows the addressed register combinationally. Writing zero to a match register makes later lookups of that page miss.
- R10: A response appears exactly one cycle after each request and at no other time. `rsp_miss` and `rsp_fault` are never high together: a miss takes precedence. On either exception `rsp_pa` is zero.
- R11: On a permitted hit, `rsp_nocache` equals translate-register bit 0 of the hitting entry. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable |
| priv_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_ea | input | 32 | Effective address of the access |
| cfg_wr | input | 1 | Table register write strobe |
| cfg_sel_tr | input | 1 | Register select: 0 match, 1 translate |
| cfg_way | input | WAY_W | Way index for table access |
| cfg_set | input | SET_W | Set index for table access |
| cfg_wdata | input | 32 | Table register write data |
| cfg_rdata | output | 32 | Addressed table register contents |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_pa | output | 32 | Physical address |
| rsp_nocache | output | 1 | Cache-inhibit attribute of the access |
| rsp_miss | output | 1 | No valid way matched |
| rsp_fault | output | 1 | Access denied by permissions |
| fault_addr | output | 32 | Effective address of the latest exception |

## Verification
Lookup results (`rsp_valid`, `rsp_pa`, `rsp_nocache`, `rsp_miss`, `rsp_fault`, `fault_addr`) pass through a single register. They are due on the first clock edge after the one that samples the request. The bench drives each request at a falling edge and checks it at the next falling edge, half a period after the capturing edge. `cfg_rdata` is combinational from the table, so a write takes effect at the edge where it is sampled. Read-backs are checked at the falling edge after the write. Idle cycles are checked to show that no response appears without a request.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
   localparam int VA_W    = 32;
   localparam int PG_BITS = 12;
   localparam int VPN_W   = VA_W - PG_BITS;
   localparam int PERM_W  = 5;

   // match register
   localparam int MR_VALID = 0;
   // translate register attribute bits
   localparam int TR_NC  = 0;
   localparam int TR_URE = 1;
   localparam int TR_UWE = 2;
   localparam int TR_SRE = 3;
   localparam int TR_SWE = 4;

   typedef struct packed {
      logic              hit;
      logic [VPN_W-1:0]  ppn;
      logic [PERM_W-1:0] perm;
   } way_look_t;

   function automatic logic access_ok(input logic [PERM_W-1:0] perm,
                                      input logic is_sup, input logic is_wr);
      case ({is_sup, is_wr})
         2'b00:   access_ok = perm[TR_URE];
         2'b01:   access_ok = perm[TR_UWE];
         2'b10:   access_ok = perm[TR_SRE];
         default: access_ok = perm[TR_SWE];
      endcase
   endfunction
endpackage

// File: rtl/dtlb_way.sv
module dtlb_way
   import dtlb_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int SET_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel_tr,
   input  logic [SET_W-1:0] acc_set,
   input  logic [VA_W-1:0]  wr_data,
   output logic [VA_W-1:0]  rd_data,
   input  logic [SET_W-1:0] lk_set,
   input  logic [VPN_W-1:0] lk_vpn,
   output way_look_t        lk
);
   logic [VA_W-1:0] mr_q [NUM_SETS];
   logic [VA_W-1:0] tr_q [NUM_SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            mr_q[s] <= '0;
            tr_q[s] <= '0;
         end
      end else if (wr_en) begin
         if (wr_sel_tr) tr_q[acc_set] <= wr_data;
         else           mr_q[acc_set] <= wr_data;
      end
   end

   assign rd_data = wr_sel_tr ? tr_q[acc_set] : mr_q[acc_set];

   logic [VA_W-1:0] mr_sel, tr_sel;
   assign mr_sel  = mr_q[lk_set];
   assign tr_sel  = tr_q[lk_set];
   assign lk.hit  = mr_sel[MR_VALID] && (mr_sel[VA_W-1:PG_BITS] == lk_vpn);
   assign lk.ppn  = tr_sel[VA_W-1:PG_BITS];
   assign lk.perm = tr_sel[PERM_W-1:0];
endmodule

// File: rtl/dtlb_pick.sv
module dtlb_pick
   import dtlb_pkg::*;
#(
   parameter int NUM_WAYS = 2
) (
   input  way_look_t         looks [NUM_WAYS],
   output logic              any_hit,
   output logic [VPN_W-1:0]  ppn,
   output logic [PERM_W-1:0] perm
);
   generate
      if (NUM_WAYS == 1) begin : g_single
         assign any_hit = looks[0].hit;
         assign ppn     = looks[0].ppn;
         assign perm    = looks[0].perm;
      end else begin : g_multi
         always_comb begin
            any_hit = 1'b0;
            ppn     = '0;
            perm    = '0;
            for (int w = NUM_WAYS - 1; w >= 0; w--) begin
               if (looks[w].hit) begin
                  any_hit = 1'b1;
                  ppn     = looks[w].ppn;
                  perm    = looks[w].perm;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
   import dtlb_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 2,
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xlate_en,
   input  logic             priv_super,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [31:0]      req_ea,
   input  logic             cfg_wr,
   input  logic             cfg_sel_tr,
   input  logic [WAY_W-1:0] cfg_way,
   input  logic [SET_W-1:0] cfg_set,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   output logic             rsp_valid,
   output logic [31:0]      rsp_pa,
   output logic             rsp_nocache,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [31:0]      fault_addr
);
   generate
      if (NUM_SETS < 2 || NUM_SETS > 256 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
         $error("dtlb_xlate: NUM_SETS must be a power of two from 2 to 256");
      end
      if (NUM_WAYS < 1 || NUM_WAYS > 4) begin : g_bad_ways
         $error("dtlb_xlate: NUM_WAYS must be 1 to 4");
      end
   endgenerate

   logic [SET_W-1:0] lk_set;
   logic [VPN_W-1:0] lk_vpn;
   assign lk_set = req_ea[PG_BITS +: SET_W];
   assign lk_vpn = req_ea[VA_W-1:PG_BITS];

   way_look_t   looks  [NUM_WAYS];
   logic [31:0] rd_arr [NUM_WAYS];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      dtlb_way #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_wr && (cfg_way == WAY_W'(w))),
         .wr_sel_tr (cfg_sel_tr),
         .acc_set   (cfg_set),
         .wr_data   (cfg_wdata),
         .rd_data   (rd_arr[w]),
         .lk_set    (lk_set),
         .lk_vpn    (lk_vpn),
         .lk        (looks[w])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int w = 0; w < NUM_WAYS; w++)
         if (cfg_way == WAY_W'(w)) cfg_rdata = rd_arr[w];
   end

   logic              any_hit;
   logic [VPN_W-1:0]  hit_ppn;
   logic [PERM_W-1:0] hit_perm;

   dtlb_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
      .looks   (looks),
      .any_hit (any_hit),
      .ppn     (hit_ppn),
      .perm    (hit_perm)
   );

   logic [31:0] nx_pa;
   logic        nx_nc, nx_miss, nx_fault;

   always_comb begin
      nx_pa    = '0;
      nx_nc    = 1'b0;
      nx_miss  = 1'b0;
      nx_fault = 1'b0;
      if (!xlate_en) begin
         nx_pa = req_ea;
      end else if (!any_hit) begin
         nx_miss = 1'b1;
      end else if (!access_ok(hit_perm, priv_super, req_write)) begin
         nx_fault = 1'b1;
      end else begin
         nx_pa = {hit_ppn, req_ea[PG_BITS-1:0]};
         nx_nc = hit_perm[TR_NC];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_pa      <= '0;
         rsp_nocache <= 1'b0;
         rsp_miss    <= 1'b0;
         rsp_fault   <= 1'b0;
         fault_addr  <= '0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_pa      <= req_valid ? nx_pa : '0;
         rsp_nocache <= req_valid && nx_nc;
         rsp_miss    <= req_valid && nx_miss;
         rsp_fault   <= req_valid && nx_fault;
         if (req_valid && (nx_miss || nx_fault)) fault_addr <= req_ea;
      end
   end
endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        xlate_en,
   input logic        req_valid,
   input logic [31:0] req_ea,
   input logic        rsp_valid,
   input logic [31:0] rsp_pa,
   input logic        rsp_miss,
   input logic        rsp_fault,
   input logic [31:0] fault_addr
);
   a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xlate_en) |=> (rsp_pa == $past(req_ea) && !rsp_miss && !rsp_fault));

   a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss && !rsp_fault) |-> (rsp_pa[11:0] == $past(req_ea[11:0])));

   a_r6_addr_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_miss || rsp_fault) |-> (fault_addr == $past(req_ea)));

   a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_miss || rsp_fault) |-> $stable(fault_addr));

   a_r10_one_exception: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_miss && rsp_fault));

   a_r10_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_miss || rsp_fault) |-> (rsp_pa == 32'h0 && rsp_valid));

   a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
endmodule

bind dtlb_xlate dtlb_xlate_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xlate_en   (xlate_en),
   .req_valid  (req_valid),
   .req_ea     (req_ea),
   .rsp_valid  (rsp_valid),
   .rsp_pa     (rsp_pa),
   .rsp_miss   (rsp_miss),
   .rsp_fault  (rsp_fault),
   .fault_addr (fault_addr)
);

// File: tb/dtlb_xlate_test.sv
module dtlb_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlate_en = 1'b0, priv_super = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_ea = '0;
   logic        cfg_wr = 1'b0, cfg_sel_tr = 1'b0;
   logic [0:0]  cfg_way = '0;
   logic [3:0]  cfg_set = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata, rsp_pa, fault_addr;
   logic        rsp_valid, rsp_nocache, rsp_miss, rsp_fault;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_fa = '0;

   always #10 clk = ~clk;

   dtlb_xlate #(.NUM_SETS(16), .NUM_WAYS(2)) uut (
      .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .priv_super(priv_super),
      .req_valid(req_valid), .req_write(req_write), .req_ea(req_ea),
      .cfg_wr(cfg_wr), .cfg_sel_tr(cfg_sel_tr), .cfg_way(cfg_way), .cfg_set(cfg_set),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid),
      .rsp_pa(rsp_pa), .rsp_nocache(rsp_nocache), .rsp_miss(rsp_miss),
      .rsp_fault(rsp_fault), .fault_addr(fault_addr)
   );

   // {en, sup, wr, ea, miss, fault, nc, pa}
   localparam int NV = 19;
   localparam logic [69:0] VEC [NV] = '{
      {3'b010, 32'hDEADBEEF, 3'b000, 32'hDEADBEEF},  // R2 pass-through
      {3'b110, 32'h12343ABC, 3'b001, 32'hABCDEABC},  // R3 R11
      {3'b101, 32'h12343000, 3'b001, 32'hABCDE000},  // R5 first byte
      {3'b100, 32'h12343FFC, 3'b001, 32'hABCDEFFC},  // R5 last word
      {3'b100, 32'h12344000, 3'b100, 32'h00000000},  // R5 next page
      {3'b100, 32'h12342FFC, 3'b100, 32'h00000000},  // R5 previous page
      {3'b100, 32'h92343000, 3'b100, 32'h00000000},  // R5 bit 31
      {3'b100, 32'h12353000, 3'b100, 32'h00000000},  // R5 bit 16
      {3'b110, 32'h70007010, 3'b100, 32'h00000000},  // R4 invalid entry
      {3'b110, 32'h00009123, 3'b000, 32'h11111123},  // R8 lowest way
      {3'b110, 32'h00005040, 3'b000, 32'h55555040},  // R7 sup read ok
      {3'b111, 32'h00005040, 3'b010, 32'h00000000},  // R7 sup write denied
      {3'b101, 32'h00005044, 3'b010, 32'h00000000},  // R7 user write denied
      {3'b100, 32'h00005048, 3'b000, 32'h55555048},  // R7 user read ok
      {3'b100, 32'h00102010, 3'b000, 32'h33333010},  // R7 user read only
      {3'b101, 32'h00102014, 3'b010, 32'h00000000},  // R7
      {3'b110, 32'h00102018, 3'b010, 32'h00000000},  // R7
      {3'b111, 32'h0010201C, 3'b010, 32'h00000000},  // R7
      {3'b001, 32'h00005040, 3'b000, 32'h00005040}   // R2 no fault when off
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_put(input logic tr, input logic w, input logic [3:0] s, input logic [31:0] d);
      cfg_sel_tr = tr; cfg_way = w; cfg_set = s; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic lookup(input logic en, input logic sup, input logic wr, input logic [31:0] ea);
      xlate_en = en; priv_super = sup; req_write = wr; req_ea = ea; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #4000000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
      chk("R1 rsp_pa", rsp_pa, 32'h0);
      chk("R1 flags", {29'b0, rsp_miss, rsp_fault, rsp_nocache}, 32'h0);
      chk("R1 fault_addr", fault_addr, 32'h0);
      cfg_sel_tr = 1'b1; cfg_way = 1'b1; cfg_set = 4'd5; #1;
      chk("R1 table zero", cfg_rdata, 32'h0);

      cfg_put(1'b0, 1'b0, 4'd3, 32'h12343001); cfg_put(1'b1, 1'b0, 4'd3, 32'hABCDE01F);
      cfg_put(1'b0, 1'b1, 4'd5, 32'h00005001); cfg_put(1'b1, 1'b1, 4'd5, 32'h5555500A);
      cfg_put(1'b0, 1'b0, 4'd7, 32'h70007000); cfg_put(1'b1, 1'b0, 4'd7, 32'h7777701E);
      cfg_put(1'b0, 1'b0, 4'd9, 32'h00009001); cfg_put(1'b1, 1'b0, 4'd9, 32'h1111101E);
      cfg_put(1'b0, 1'b1, 4'd9, 32'h00009001); cfg_put(1'b1, 1'b1, 4'd9, 32'h2222201E);
      cfg_put(1'b0, 1'b1, 4'd2, 32'h00102001); cfg_put(1'b1, 1'b1, 4'd2, 32'h33333002);

      for (int i = 0; i < NV; i++) begin
         logic [69:0] v;
         v = VEC[i];
         lookup(v[69], v[68], v[67], v[66:35]);
         if (v[34] || v[33]) exp_fa = v[66:35];
         chk($sformatf("R10 valid v%0d", i), {31'b0, rsp_valid}, 32'h1);
         chk($sformatf("R5/R4 miss v%0d", i), {31'b0, rsp_miss}, {31'b0, v[34]});
         chk($sformatf("R7 fault v%0d", i), {31'b0, rsp_fault}, {31'b0, v[33]});
         chk($sformatf("R11 nocache v%0d", i), {31'b0, rsp_nocache}, {31'b0, v[32]});
         chk($sformatf("R3 pa v%0d", i), rsp_pa, v[31:0]);
         chk($sformatf("R6 fault_addr v%0d", i), fault_addr, exp_fa);
      end

      // R10 idle: no response without a request
      @(negedge clk);
      chk("R10 idle valid", {31'b0, rsp_valid}, 32'h0);
      chk("R10 idle miss", {31'b0, rsp_miss}, 32'h0);

      // R9 read back
      cfg_sel_tr = 1'b1; cfg_way = 1'b1; cfg_set = 4'd5; #1;
      chk("R9 read translate", cfg_rdata, 32'h5555500A);
      cfg_sel_tr = 1'b0; #1;
      chk("R9 read match", cfg_rdata, 32'h00005001);

      // R9 invalidate by writing zero
      cfg_put(1'b0, 1'b0, 4'd3, 32'h0);
      cfg_sel_tr = 1'b0; cfg_way = 1'b0; cfg_set = 4'd3; #1;
      chk("R9 cleared", cfg_rdata, 32'h0);
      lookup(1'b1, 1'b1, 1'b0, 32'h12343000);
      chk("R9 miss after clear", {31'b0, rsp_miss}, 32'h1);
      chk("R6 addr after clear", fault_addr, 32'h12343000);

      // R8 drop way 0 of set 9: way 1 takes over
      cfg_put(1'b0, 1'b0, 4'd9, 32'h0);
      lookup(1'b1, 1'b1, 1'b1, 32'h00009ABC);
      chk("R8 way1 pa", rsp_pa, 32'h22222ABC);
      chk("R6 addr held", fault_addr, 32'h12343000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule